// File: doc/BRIEF.md
# Walking LED Sequencer

This block drives a row of LEDs in a repeating walk. After reset every output is dark for one dwell interval. Then the lowest LED lights on its own for one dwell interval, and all LEDs go dark for another dwell interval. The lit position then moves up by one. After the highest LED has had its turn, the walk returns to the lowest LED and carries on for as long as the clock runs.

The dwell length is a count of clock cycles and is set by a parameter. The default, 458,745 cycles, gives about 0.459 s per phase at 1 MHz. A simulation can set it to a few cycles. The reset input is asynchronous and active low, and its release is synchronised inside the block. The output follows the internal registers with no further register stage.

Top module: `walk_led_seq`

## Requirements
- R1: While `rst_n` is low, `leds` is all zero, and it goes to zero at once when `rst_n` falls, without waiting for a clock edge. After `rst_n` rises, `leds` stays zero for DWELL_CLKS + 2 rising clock edges: two edges of reset-release synchronisation, then one dark dwell.
- R2: The first lit pattern after reset has only bit 0 set. It appears on edge DWELL_CLKS + 2 after `rst_n` rises.
- R3: During every lit phase exactly one bit of `leds` is set, and the pattern is held for exactly DWELL_CLKS cycles.
- R4: Every lit phase is followed by a dark phase in which `leds` is all zero for exactly DWELL_CLKS cycles.
- R5: Each lit pattern other than the first after a wrap is the previous lit pattern shifted left by one position.
- R6: After the lit phase with bit NUM_LEDS-1 set, and the dark phase that follows it, the next lit pattern is bit 0 only. The walk repeats indefinitely.
- R7: The phase length follows DWELL_CLKS for any value of 1 or more. With DWELL_CLKS = 1, lit and dark alternate on every cycle.
- R8: Pulling `rst_n` low in the middle of a walk restarts the sequence from the state described in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| leds | output | NUM_LEDS | LED drive; a 1 lights the LED |

## Verification
Every output is a function of the number of rising edges since `rst_n` rose. The first two edges belong to the reset synchroniser. After that, phase p spans edges 2 + p·DWELL_CLKS through 2 + (p+1)·DWELL_CLKS - 1, with p = 0 dark, odd p lit at position ((p-1)/2) mod 16, and other even p dark. The bench counts edges and samples on the falling edge after each one, so every comparison falls half a cycle after the registers change. The expected pattern is computed from that edge count alone. The asynchronous reset (R1, R8) is checked one time unit after `rst_n` falls, before any clock edge.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic {
    PH_DARK = 1'b0,
    PH_LIT  = 1'b1
  } phase_e;
endpackage

// File: rtl/walk_rst_sync.sv
module walk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/walk_dwell_timer.sv
module walk_dwell_timer #(
  parameter int unsigned DWELL_CLKS = 458745
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int unsigned CW = (DWELL_CLKS > 1) ? $clog2(DWELL_CLKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DWELL_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = (cnt_q == '0);

  always_comb begin
    if (expire) cnt_d = RELOAD;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  // R3/R4: a phase ends with a full reload, so every phase lasts DWELL_CLKS cycles
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == RELOAD));
  // R7: the count only moves down one step at a time between reloads
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/walk_onehot_ring.sv
module walk_onehot_ring #(
  parameter int unsigned NUM_LEDS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [NUM_LEDS-1:0] onehot
);
  localparam int unsigned PW = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_LEDS - 1);

  logic [NUM_LEDS-1:0] ring_q, ring_d;
  logic [PW-1:0]       pos_q, pos_d;

  always_comb begin
    ring_d = ring_q;
    pos_d  = pos_q;
    if (advance) begin
      ring_d = {ring_q[NUM_LEDS-2:0], ring_q[NUM_LEDS-1]};
      pos_d  = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  // reset parks on the top position so the first advance lands on bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= {1'b1, {(NUM_LEDS-1){1'b0}}};
      pos_q  <= LAST;
    end else begin
      ring_q <= ring_d;
      pos_q  <= pos_d;
    end
  end

  assign onehot = ring_q;

  // R5: shift ring and position counter agree at all times
  a_r5_pos_match: assert property (@(posedge clk) disable iff (!rst_n)
    ring_q == (NUM_LEDS'(1) << pos_q));
  // R6: stepping past the top position returns to bit 0
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && pos_q == LAST) |=> (pos_q == '0 && ring_q[0]));
  // R3: never more or less than one bit in the ring
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);
endmodule

// File: rtl/walk_led_seq.sv
module walk_led_seq #(
  parameter int unsigned NUM_LEDS   = 16,
  parameter int unsigned DWELL_CLKS = 458745
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_LEDS-1:0] leds
);
  import walk_pkg::*;

  logic                rst_n_sync;
  logic                expire;
  logic                advance;
  logic [NUM_LEDS-1:0] onehot;
  phase_e              phase_q, phase_d;

  walk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  walk_dwell_timer #(.DWELL_CLKS(DWELL_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .expire (expire)
  );

  walk_onehot_ring #(.NUM_LEDS(NUM_LEDS)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .advance (advance),
    .onehot  (onehot)
  );

  // next-state: the phase flips whenever the dwell expires
  always_comb begin
    phase_d = phase_q;
    if (expire) phase_d = (phase_q == PH_LIT) ? PH_DARK : PH_LIT;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) phase_q <= PH_DARK;
    else             phase_q <= phase_d;
  end

  // the ring moves on entry to a lit phase
  assign advance = expire && (phase_q == PH_DARK);
  assign leds    = (phase_q == PH_LIT) ? onehot : '0;

  // R4: phase holds until the timer expires
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !expire |=> $stable(phase_q));
  // R3: the lit pattern does not move inside a lit phase
  a_r3_lit_stable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phase_q == PH_LIT && !expire) |=> $stable(leds));
  // R4: an expiring lit phase produces a dark output next
  a_r4_dark_follows: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (phase_q == PH_LIT && expire) |=> (leds == '0));
  // R1: output is dark whenever the synchronised reset is active
  a_r1_reset_dark: assert property (@(posedge clk)
    !rst_n_sync |-> (leds == '0));
endmodule

// File: tb/walk_led_seq_bench.sv
module walk_led_seq_bench;
  localparam int N      = 16;
  localparam int DW_A   = 3;
  localparam int DW_B   = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] leds_a, leds_b;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  walk_led_seq #(.NUM_LEDS(N), .DWELL_CLKS(DW_A)) u_walk_led_seq (
    .clk(clk), .rst_n(rst_n), .leds(leds_a));

  walk_led_seq #(.NUM_LEDS(N), .DWELL_CLKS(DW_B)) u_walk_led_seq_min (
    .clk(clk), .rst_n(rst_n), .leds(leds_b));

  function automatic logic [N-1:0] expect_leds(int e, int dw);
    int k, p;
    k = e - 2;
    if (k < dw) return '0;
    p = k / dw;
    if (p % 2 == 1) return N'(1) << (((p - 1) / 2) % N);
    return '0;
  endfunction

  function automatic string tag_of(int e, int dw);
    int k, p, pos;
    k = e - 2;
    if (k < dw) return "R1";
    p = k / dw;
    if (p % 2 == 0) return "R4";
    pos = ((p - 1) / 2);
    if (pos == 0) return "R2";
    if (pos % N == 0) return "R6";
    return "R5";
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h edge=%0d", req, act, exp, edges);
    end
  endtask

  task automatic run_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      check(tag_of(edges, DW_A), leds_a, expect_leds(edges, DW_A));
      if (expect_leds(edges, DW_A) != '0) begin
        checks++;
        if ($countones(leds_a) != 1) begin
          errors++;
          $display("FAIL R3 actual=%0d expected=1 bits set", $countones(leds_a));
        end
      end
      check("R7", leds_b, expect_leds(edges, DW_B));
    end
  endtask

  initial begin
    #1;
    check("R1", leds_a, '0);
    repeat (3) @(negedge clk);
    check("R1", leds_a, '0);
    rst_n = 1'b1;
    edges = 0;
    // walk two full rounds plus a margin in the DWELL=3 instance
    run_edges(2 + 2 * 2 * N * DW_A + 10);
    // R8: asynchronous restart mid-walk
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", leds_a, '0);
    check("R8", leds_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    run_edges(2 + 2 * N * DW_A + 8);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule